// File: doc/BRIEF.md
# Gated Sample Capture Controller

This block sits behind a free-running converter whose samples never stop. It decides which of those samples get stored in a snapshot buffer. A sample is stored only when three things hold: capture is armed, the capture gate is high, and the sample strobe is high. The buffer is never paused or back-pressured. Capture begins on a transmit sync pulse, so the first stored sample sits at a frame boundary. If the buffer length is chosen as a multiple of the frame length, the snapshot holds a whole number of frames.

Software programs a length in samples and issues a restart. The block then waits for the next sync pulse. From there it emits one write strobe per accepted sample, with an address that counts up from zero, until the programmed count is reached. It then raises a full flag and discards every further sample until the next restart. The memory that takes the writes and the processing that reads the snapshot sit outside this block.

Top module: `snap_capture_top`

## Requirements
- R1: After reset the block is idle. It makes no write, `buf_full` is 0 and `smp_count` is 0, even if sync, gate and valid are all high.
- R2: After a restart and before the next sync pulse, no sample is written, whatever the gate and valid inputs do.
- R3: A sample that has valid and gate high in the same cycle as the arming sync pulse is written at address 0. Its write strobe appears in the following cycle.
- R4: While capturing, a sample is written only when both `smp_vld` and `cap_gate` are high. The write strobe, address and data appear one cycle after the sample is presented, and `wr_data` equals that sample.
- R5: Write addresses of one snapshot are 0, 1, 2, … with no gaps. In every write cycle `smp_count` equals `wr_addr` + 1.
- R6: `buf_full` rises in the same cycle as the write strobe of the sample that brings the count to the programmed length.
- R7: Once `buf_full` is high, no further writes occur and `buf_full` stays high until a restart.
- R8: A restart clears `smp_count` and `buf_full` and re-arms the block to wait for a sync pulse. The length in `buf_len` (in samples, 1 to 2^AW) is captured at the restart. Later changes to `buf_len` have no effect on the running snapshot.
- R9: A sync pulse that arrives while a capture is in progress is ignored. Addresses continue from where they were.
- R10: A restart takes precedence over a sample, a gate and a sync pulse in the same cycle. That sample is not written and the block stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_data | input | DW | Incoming converter sample |
| smp_vld | input | 1 | Strobe marking a valid sample |
| cap_gate | input | 1 | Capture window; samples outside it are skipped |
| frm_sync | input | 1 | Transmit sync pulse marking a frame start |
| buf_len | input | AW+1 | Snapshot length in samples, captured at restart |
| restart | input | 1 | Clears the snapshot and arms for the next sync |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | DW | Sample to store |
| buf_full | output | 1 | Snapshot complete |
| smp_count | output | AW+1 | Number of samples stored in this snapshot |

## Verification
A wrong capture state has one of two effects at the ports. Either the write strobe appears where it must not, such as before the sync pulse, after the full flag or in a restart cycle, or it is missing one cycle after a gated, valid sample. Either way the fault shows within one clock of the stimulus. A corrupted address counter shows up at the very next write, as a gap in the address sequence or as a count that no longer equals address plus one. A wrong length comparison shows up as the full flag rising one write early or late. The directed scenarios cover a held gate, a toggling gate, a mid-run sync pulse, restart precedence and a length change after restart.

// File: rtl/snap_cap_pkg.sv
// Shared types for the gated sample capture controller.
package snap_cap_pkg;
    // Capture sequence: idle after reset, armed after restart, running after sync, full at limit
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_FULL  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/snap_arm_fsm.sv
// Capture sequencer. A restart moves the sequencer to ARMED, and a sync pulse
// while ARMED starts the run. The last accepted sample moves it to FULL.
// Assumes restart outranks every other input and that sync pulses during RUN
// or FULL are to be ignored.
module snap_arm_fsm
    import snap_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       frm_sync,
    input  logic       acc_last,
    output cap_state_e state
);
    // State register with restart priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else if (restart) begin
            state <= CAP_ARMED;
        end else begin
            case (state)
                CAP_ARMED: if (frm_sync) state <= acc_last ? CAP_FULL : CAP_RUN;
                CAP_RUN:   if (acc_last) state <= CAP_FULL;
                default:   state <= state;
            endcase
        end
    end
endmodule

// File: rtl/snap_addr_cnt.sv
// Stored-sample counter. Counts accepted samples from zero and flags the
// sample that reaches the programmed length. Assumes len is between 1 and
// 2^(CW-1), so the counter never wraps.
module snap_addr_cnt #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] cnt,
    output logic          last
);
    // Count accepted samples, cleared by restart
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (inc)  cnt <= cnt + CW'(1);
    end

    // Flag the accept that reaches the limit
    always_comb last = inc && ((cnt + CW'(1)) == len);
endmodule

// File: rtl/snap_wr_stage.sv
// Output register for buffer writes. It turns an accept into a write strobe one
// cycle later, carrying the pre-increment count as the address together with
// the sample. Assumes addr_in already holds the next free slot.
module snap_wr_stage #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    // Strobe register, one pulse per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) wr_en <= 1'b0;
        else        wr_en <= acc;
    end

    // Address and data register, loaded only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (acc) begin
            wr_addr <= addr_in;
            wr_data <= data_in;
        end
    end
endmodule

// File: rtl/snap_capture_top.sv
// Gated sample capture controller. Samples from a free-running stream are
// written only while armed by a sync pulse, inside the capture gate, and until
// the programmed length is reached. The length is captured at restart.
// Assumes buf_len is between 1 and 2^AW when restart is pulsed.
module snap_capture_top
    import snap_cap_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_data,
    input  logic          smp_vld,
    input  logic          cap_gate,
    input  logic          frm_sync,
    input  logic [AW:0]   buf_len,
    input  logic          restart,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          buf_full,
    output logic [AW:0]   smp_count
);
    localparam int CW = AW + 1;

    cap_state_e    state;
    logic [CW-1:0] len_q;
    logic [CW-1:0] cnt;
    logic          run_en;
    logic          acc;
    logic          acc_last;

    // Capture the snapshot length at restart
    always_ff @(posedge clk) begin
        if (!rst_n)       len_q <= '0;
        else if (restart) len_q <= buf_len;
    end

    // A sample is accepted while running, or in the sync cycle when armed
    always_comb begin
        run_en = (state == CAP_RUN) || ((state == CAP_ARMED) && frm_sync);
        acc    = run_en && smp_vld && cap_gate && !restart;
    end

    snap_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .frm_sync (frm_sync),
        .acc_last (acc_last),
        .state    (state)
    );

    snap_addr_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .inc   (acc),
        .len   (len_q),
        .cnt   (cnt),
        .last  (acc_last)
    );

    snap_wr_stage #(.DW(DW), .AW(AW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .addr_in (cnt[AW-1:0]),
        .data_in (smp_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Status outputs
    always_comb begin
        buf_full  = (state == CAP_FULL);
        smp_count = cnt;
    end
endmodule

// File: rtl/snap_capture_chk.sv
// Port-level checker for snap_capture_top. It is bound into every instance of
// the top module.
module snap_capture_chk #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] smp_data,
    input logic          smp_vld,
    input logic          cap_gate,
    input logic          restart,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          buf_full,
    input logic [AW:0]   smp_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !restart) |=> (!wr_en && buf_full)); // R7

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(smp_vld && cap_gate && !restart)); // R4

    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == $past(smp_data))); // R4

    AST_COUNT_TRACKS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (smp_count == ({1'b0, wr_addr} + 1'b1))); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restart) |=> (!wr_en || (wr_addr == $past(wr_addr) + 1'b1))); // R5

    AST_FULL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> wr_en); // R6

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (smp_count == '0 && !buf_full && !wr_en)); // R8
endmodule

bind snap_capture_top snap_capture_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_data  (smp_data),
    .smp_vld   (smp_vld),
    .cap_gate  (cap_gate),
    .restart   (restart),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .buf_full  (buf_full),
    .smp_count (smp_count)
);

// File: tb/snap_capture_top_tb_top.sv
// Directed bench for snap_capture_top: one task per scenario.
module snap_capture_top_tb_top;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          smp_vld = 1'b0;
    logic          cap_gate = 1'b0;
    logic          frm_sync = 1'b0;
    logic [AW:0]   buf_len = '0;
    logic          restart = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          buf_full;
    logic [AW:0]   smp_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    snap_capture_top #(.DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
        .cap_gate(cap_gate), .frm_sync(frm_sync), .buf_len(buf_len),
        .restart(restart), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .buf_full(buf_full), .smp_count(smp_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one cycle of inputs, then sample just after the edge
    task automatic step(input bit s, input bit g, input bit v, input int d, input bit r);
        frm_sync = s; cap_gate = g; smp_vld = v; smp_data = DW'(d); restart = r;
        @(posedge clk); #2;
        frm_sync = 1'b0; restart = 1'b0; smp_vld = 1'b0;
    endtask

    task automatic expect_write(input string req, input int addr, input int data, input int cnt);
        chk(wr_en == 1'b1, req, wr_en, 1);
        chk(int'(wr_addr) == addr, req, wr_addr, addr);
        chk(int'(wr_data) == data, req, wr_data, data);
        chk(int'(smp_count) == cnt, req, smp_count, cnt);
    endtask

    task automatic t_reset();
        @(posedge clk); #2;
        chk(wr_en == 1'b0, "R1", wr_en, 0);
        chk(buf_full == 1'b0, "R1", buf_full, 0);
        chk(smp_count == '0, "R1", smp_count, 0);
        step(1, 1, 1, 16'h55, 0);
        chk(wr_en == 1'b0, "R1", wr_en, 0);
        chk(smp_count == '0, "R1", smp_count, 0);
    endtask

    task automatic t_arm_and_fill();
        buf_len = 9'd4;
        step(0, 0, 0, 0, 1);
        chk(smp_count == '0 && !buf_full, "R8", smp_count, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 1, 16'h10 + i, 0);
            chk(wr_en == 1'b0, "R2", wr_en, 0);
        end
        step(1, 1, 1, 16'h100, 0);
        expect_write("R3", 0, 16'h100, 1);
        step(0, 0, 1, 16'h101, 0);
        chk(wr_en == 1'b0, "R4", wr_en, 0);
        step(0, 1, 0, 16'h102, 0);
        chk(wr_en == 1'b0, "R4", wr_en, 0);
        step(0, 1, 1, 16'h103, 0);
        expect_write("R5", 1, 16'h103, 2);
        step(0, 0, 1, 16'h104, 0);
        chk(wr_en == 1'b0, "R4", wr_en, 0);
        step(0, 1, 1, 16'h105, 0);
        expect_write("R5", 2, 16'h105, 3);
        chk(buf_full == 1'b0, "R6", buf_full, 0);
        step(0, 1, 1, 16'h106, 0);
        expect_write("R6", 3, 16'h106, 4);
        chk(buf_full == 1'b1, "R6", buf_full, 1);
        for (int i = 0; i < 4; i++) begin
            step(i == 1, 1, 1, 16'h200 + i, 0);
            chk(wr_en == 1'b0, "R7", wr_en, 0);
            chk(buf_full == 1'b1, "R7", buf_full, 1);
            chk(smp_count == 9'd4, "R7", smp_count, 4);
        end
    endtask

    task automatic t_sync_mid_run();
        buf_len = 9'd6;
        step(0, 0, 0, 0, 1);
        chk(!buf_full && smp_count == '0, "R8", buf_full, 0);
        step(1, 1, 1, 16'h300, 0);
        expect_write("R3", 0, 16'h300, 1);
        step(0, 1, 1, 16'h301, 0);
        expect_write("R5", 1, 16'h301, 2);
        step(1, 1, 1, 16'h302, 0);
        expect_write("R9", 2, 16'h302, 3);
    endtask

    task automatic t_restart_priority();
        step(1, 1, 1, 16'h400, 1);
        chk(wr_en == 1'b0, "R10", wr_en, 0);
        chk(smp_count == '0, "R10", smp_count, 0);
        step(0, 1, 1, 16'h401, 0);
        chk(wr_en == 1'b0, "R10", wr_en, 0);
        step(1, 1, 1, 16'h402, 0);
        expect_write("R10", 0, 16'h402, 1);
    endtask

    task automatic t_len_latched();
        buf_len = 9'd3;
        step(0, 0, 0, 0, 1);
        buf_len = 9'd10;
        step(1, 1, 1, 16'h500, 0);
        expect_write("R8", 0, 16'h500, 1);
        step(0, 1, 1, 16'h501, 0);
        step(0, 1, 1, 16'h502, 0);
        expect_write("R8", 2, 16'h502, 3);
        chk(buf_full == 1'b1, "R8", buf_full, 1);
        step(0, 1, 1, 16'h503, 0);
        chk(wr_en == 1'b0, "R8", wr_en, 0);
    endtask

    task automatic t_single_sample();
        buf_len = 9'd1;
        step(0, 0, 0, 0, 1);
        step(1, 1, 1, 16'h600, 0);
        expect_write("R6", 0, 16'h600, 1);
        chk(buf_full == 1'b1, "R6", buf_full, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_arm_and_fill();
        t_sync_mid_run();
        t_restart_priority();
        t_len_latched();
        t_single_sample();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule